// File: doc/BRIEF.md
# NAND Flash Programmed-I/O Command Sequencer

This block drives a raw 8-bit NAND flash bus from a handful of registers. Software loads two command bytes, two address words, a data word and a control word. Setting the start bit in the control word launches one complete flash transaction in hardware. The control word decides which phases run: a leading command byte, zero to five address bytes, an optional data transfer of one to four bytes in either direction, and an optional trailing command byte. The trailing command is placed either before the data or after it.

While a transaction runs, the start bit reads back as set and register writes are dropped. The block asserts the chip enable if asked to. It paces every write and read strobe with fixed low and high widths, and it waits on the device's ready/busy line after a trailing command and again before it finishes. Received bytes are packed into the 32-bit data register. A status output mirrors the synchronised ready/busy pin.

Typical flows are built from the control word alone: page read (5 address bytes, trailing command before the data, then read), block erase (3 address bytes, trailing command), column re-read (2 address bytes), page program (address bytes, write data, trailing command after the data), status read, and single command bytes.

Top module: `nand_pio_seq`

## Requirements
- R1: After synchronous reset, the outputs are idle: chip enable, write strobe and read strobe are high; CLE, ALE and the bus drive enable are low; `go_o` is 0; `data_o` is 0; `rdy_o` is 1.
- R2: Register selects on `wr_sel` are 0 cmd-A, 1 cmd-B, 2 address low word, 3 address high byte (bits 7:0), 4 control, 5 data. The control bits are: 0 start, 1 command-A phase, 2 address phase, 3 data phase, 4 receive, 5 transmit, 6 command-B enable, 7 command-B after data, 8 chip enable, 10:9 data size, 13:11 address count.
- R2 (continued): The phases always run in this order: command-A (with CLE), address, command-B before data, data, command-B after data. A phase whose bit is clear is skipped.
- R3: The address phase sends the number of bytes given in bits 13:11, with 6 and 7 treated as 5 and 0 skipping the phase. The bytes are taken from the 40-bit value {high byte, low word}, least significant byte first, with ALE high.
- R4: The data size field holds the byte count minus one. In transmit (bit 5 set, bit 4 clear), byte k on the bus is data register bits [8k+7:8k].
- R5: In receive (bit 4 set), the k-th byte read is stored in data register bits [8k+7:8k]. It is sampled as the read strobe rises. Data bytes beyond the size are left unchanged.
- R6: Command-B is sent right after the address bytes when bit 7 is clear, and after the data bytes when bit 7 is set.
- R7: After a command-B sent before the data, and again at the end of every transaction, the sequencer waits a fixed settling delay and then for `rdy_o` high. No strobe falls while the device is busy, and `rdy_o` is 1 when `go_o` clears.
- R8: `go_o` rises on the clock edge that writes a control word with bit 0 set. It stays high until the transaction completes, then returns to 0.
- R9: With control bit 8 set, `nf_ce_n` is low through every strobe of the transaction. With it clear, `nf_ce_n` never goes low.
- R10: Every write or read strobe is low for exactly `T_LO` clocks and then high for `T_HI` clocks. Write and read strobes are never low together.
- R11: `rdy_o` follows `nf_rb_n` through a two-flop synchroniser, so a change on the pin appears on `rdy_o` two clock edges later.
- R12: While `go_o` is high, all register writes are ignored, including a second start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select |
| wr_data | input | 32 | Register write data |
| go_o | output | 1 | Transaction in progress (start bit read-back) |
| rdy_o | output | 1 | Synchronised ready/busy status, 1 = ready |
| data_o | output | 32 | Data register contents |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_out | output | 8 | Bus data driven to the flash |
| nf_dq_oe | output | 1 | Bus drive enable |
| nf_dq_in | input | 8 | Bus data from the flash |
| nf_rb_n | input | 1 | Flash ready/busy, 1 = ready |

## Verification
The assertions assume that the flash only reports busy after it has been given a command that starts an internal operation. They also assume that `nf_rb_n` is back to ready by the time the closing wait has seen it ready. The bench's flash model respects this: it goes busy for a fixed time only after command bytes 30h, 10h or D0h. The one test that forces the pin busy does so while the sequencer is idle. The bench also drives register writes only on falling clock edges, so every register setting is stable before the next start is accepted.

// File: rtl/nps_pkg.sv
package nps_pkg;

    localparam int CMD_W   = 8;
    localparam int WORD_W  = 32;
    localparam int HADR_W  = 8;
    localparam int NBYTES  = WORD_W / 8;
    localparam int ADR_MAX = 5;
    localparam int SEL_W   = 3;

    typedef struct packed {
        logic [2:0] nadr;      // 13:11 address byte count
        logic [1:0] size;      // 10:9  data bytes minus one
        logic       ce0;       // 8
        logic       b_after;   // 7
        logic       b_en;      // 6
        logic       tx;        // 5
        logic       rx;        // 4
        logic       pio;       // 3
        logic       ale;       // 2
        logic       cle;       // 1
        logic       go;        // 0
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic [3:0] {
        PH_IDLE  = 4'd0,
        PH_CMD1  = 4'd1,
        PH_ADDR  = 4'd2,
        PH_CMD2A = 4'd3,
        PH_WAITA = 4'd4,
        PH_DATA  = 4'd5,
        PH_CMD2B = 4'd6,
        PH_WAITB = 4'd7,
        PH_DONE  = 4'd8
    } phase_e;

    localparam logic [SEL_W-1:0] SEL_CMD1 = 3'd0;
    localparam logic [SEL_W-1:0] SEL_CMD2 = 3'd1;
    localparam logic [SEL_W-1:0] SEL_ADR1 = 3'd2;
    localparam logic [SEL_W-1:0] SEL_ADR2 = 3'd3;
    localparam logic [SEL_W-1:0] SEL_CTRL = 3'd4;
    localparam logic [SEL_W-1:0] SEL_DATA = 3'd5;

    function automatic logic [2:0] addr_count(ctrl_t c);
        return (c.nadr > 3'(ADR_MAX)) ? 3'(ADR_MAX) : c.nadr;
    endfunction

    function automatic logic data_on(ctrl_t c);
        return c.pio && (c.rx || c.tx);
    endfunction

    function automatic logic phase_on(phase_e p, ctrl_t c);
        case (p)
            PH_CMD1:  return c.cle;
            PH_ADDR:  return c.ale && (addr_count(c) != 3'd0);
            PH_CMD2A: return c.b_en && !c.b_after;
            PH_WAITA: return c.b_en && !c.b_after;
            PH_DATA:  return data_on(c);
            PH_CMD2B: return c.b_en && c.b_after;
            PH_WAITB: return 1'b1;
            PH_DONE:  return 1'b1;
            default:  return 1'b0;
        endcase
    endfunction

    // first enabled phase strictly after cur
    function automatic phase_e next_phase(phase_e cur, ctrl_t c);
        phase_e r = PH_DONE;
        for (int i = 8; i >= 1; i--) begin
            if (i > int'(cur) && phase_on(phase_e'(4'(i)), c))
                r = phase_e'(4'(i));
        end
        return r;
    endfunction

endpackage

// File: rtl/nps_rb_sync.sv
module nps_rb_sync (
    input  logic clk,
    input  logic rst,
    input  logic rb_n,
    output logic rdy
);
    logic s1, s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= rb_n;
            s2 <= s1;
        end
    end

    assign rdy = s2;
endmodule

// File: rtl/nps_regs.sv
module nps_regs
    import nps_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [SEL_W-1:0]    wr_sel,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic                done,
    input  logic                cap_en,
    input  logic [1:0]          cap_idx,
    input  logic [7:0]          cap_byte,
    output logic [CMD_W-1:0]    cmd1,
    output logic [CMD_W-1:0]    cmd2,
    output logic [WORD_W-1:0]   adr1,
    output logic [HADR_W-1:0]   adr2,
    output ctrl_t               ctrl,
    output logic [WORD_W-1:0]   data
);
    logic accept;
    assign accept = wr_en && !ctrl.go;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd1 <= '0;
            cmd2 <= '0;
            adr1 <= '0;
            adr2 <= '0;
            ctrl <= '0;
            data <= '0;
        end else begin
            if (accept) begin
                case (wr_sel)
                    SEL_CMD1: cmd1 <= wr_data[CMD_W-1:0];
                    SEL_CMD2: cmd2 <= wr_data[CMD_W-1:0];
                    SEL_ADR1: adr1 <= wr_data;
                    SEL_ADR2: adr2 <= wr_data[HADR_W-1:0];
                    SEL_CTRL: ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
                    SEL_DATA: data <= wr_data;
                    default: ;
                endcase
            end
            if (cap_en)
                data[8*cap_idx +: 8] <= cap_byte;
            if (done)
                ctrl.go <= 1'b0;
        end
    end

    AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (rst)
        ctrl.go && wr_en && wr_sel == SEL_CMD1 |=> $stable(cmd1)); // R12
    AST_GO_HOLD: assert property (@(posedge clk) disable iff (rst)
        ctrl.go && !done |=> ctrl.go); // R8
endmodule

// File: rtl/nps_engine.sv
module nps_engine
    import nps_pkg::*;
#(
    parameter int T_LO   = 2,
    parameter int T_HI   = 2,
    parameter int WB_CYC = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  ctrl_t               ctrl,
    input  logic [CMD_W-1:0]    cmd1,
    input  logic [CMD_W-1:0]    cmd2,
    input  logic [WORD_W-1:0]   adr1,
    input  logic [HADR_W-1:0]   adr2,
    input  logic [WORD_W-1:0]   data,
    input  logic                rdy,
    input  logic [7:0]          dq_in,
    output logic                ce_n,
    output logic                cle,
    output logic                ale,
    output logic                we_n,
    output logic                re_n,
    output logic [7:0]          dq_out,
    output logic                dq_oe,
    output logic                cap_en,
    output logic [1:0]          cap_idx,
    output logic [7:0]          cap_byte,
    output logic                done
);
    localparam int TMAX = (T_LO > T_HI) ? ((T_LO > WB_CYC) ? T_LO : WB_CYC)
                                        : ((T_HI > WB_CYC) ? T_HI : WB_CYC);
    localparam int TW = $clog2(TMAX + 1);
    localparam logic [TW-1:0] LO_END = TW'(T_LO - 1);
    localparam logic [TW-1:0] HI_END = TW'(T_HI - 1);
    localparam logic [TW-1:0] WB_END = TW'(WB_CYC - 1);

    phase_e          ph;
    logic            lo;
    logic [TW-1:0]   tcnt;
    logic [2:0]      bidx;

    logic [WORD_W+HADR_W-1:0] adr_cat;
    logic active, waiting, byte_ph, is_rd, is_wr, last_byte;

    assign adr_cat   = {adr2, adr1};
    assign active    = (ph != PH_IDLE) && (ph != PH_DONE);
    assign waiting   = (ph == PH_WAITA) || (ph == PH_WAITB);
    assign byte_ph   = active && !waiting;
    assign is_rd     = (ph == PH_DATA) && ctrl.rx;
    assign is_wr     = byte_ph && !is_rd;
    assign last_byte = (ph == PH_ADDR) ? (bidx == addr_count(ctrl) - 3'd1)
                     : (ph == PH_DATA) ? (bidx == {1'b0, ctrl.size})
                     : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= PH_IDLE;
            lo   <= 1'b0;
            tcnt <= '0;
            bidx <= '0;
        end else begin
            case (ph)
                PH_IDLE: begin
                    if (ctrl.go) begin
                        ph   <= next_phase(PH_IDLE, ctrl);
                        lo   <= 1'b1;
                        tcnt <= '0;
                        bidx <= '0;
                    end
                end
                PH_DONE: ph <= PH_IDLE;
                PH_WAITA, PH_WAITB: begin
                    if (tcnt != WB_END)
                        tcnt <= tcnt + 1'b1;
                    else if (rdy) begin
                        ph   <= next_phase(ph, ctrl);
                        lo   <= 1'b1;
                        tcnt <= '0;
                        bidx <= '0;
                    end
                end
                default: begin
                    if (lo) begin
                        if (tcnt == LO_END) begin
                            lo   <= 1'b0;
                            tcnt <= '0;
                        end else
                            tcnt <= tcnt + 1'b1;
                    end else if (tcnt == HI_END) begin
                        tcnt <= '0;
                        lo   <= 1'b1;
                        if (last_byte) begin
                            ph   <= next_phase(ph, ctrl);
                            bidx <= '0;
                        end else
                            bidx <= bidx + 1'b1;
                    end else
                        tcnt <= tcnt + 1'b1;
                end
            endcase
        end
    end

    always_comb begin
        case (ph)
            PH_CMD1:           dq_out = cmd1;
            PH_CMD2A, PH_CMD2B: dq_out = cmd2;
            PH_ADDR:           dq_out = adr_cat[8*bidx +: 8];
            PH_DATA:           dq_out = data[8*bidx[1:0] +: 8];
            default:           dq_out = '0;
        endcase
    end

    assign ce_n     = !(active && ctrl.ce0);
    assign cle      = (ph == PH_CMD1) || (ph == PH_CMD2A) || (ph == PH_CMD2B);
    assign ale      = (ph == PH_ADDR);
    assign we_n     = !(is_wr && lo);
    assign re_n     = !(is_rd && lo);
    assign dq_oe    = is_wr;
    assign cap_en   = is_rd && lo && (tcnt == LO_END);
    assign cap_idx  = bidx[1:0];
    assign cap_byte = dq_in;
    assign done     = (ph == PH_DONE);

    AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(cle && ale)); // R2
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!we_n && !re_n)); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        ph == PH_IDLE |-> we_n && re_n && !cle && !ale && ce_n); // R1
    AST_DONE_READY: assert property (@(posedge clk) disable iff (rst)
        ph == PH_DONE |-> rdy); // R7
endmodule

// File: rtl/nand_pio_seq.sv
module nand_pio_seq
    import nps_pkg::*;
#(
    parameter int T_LO   = 2,
    parameter int T_HI   = 2,
    parameter int WB_CYC = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [2:0]  wr_sel,
    input  logic [31:0] wr_data,
    output logic        go_o,
    output logic        rdy_o,
    output logic [31:0] data_o,
    output logic        nf_ce_n,
    output logic        nf_cle,
    output logic        nf_ale,
    output logic        nf_we_n,
    output logic        nf_re_n,
    output logic [7:0]  nf_dq_out,
    output logic        nf_dq_oe,
    input  logic [7:0]  nf_dq_in,
    input  logic        nf_rb_n
);
    ctrl_t             ctrl;
    logic [CMD_W-1:0]  cmd1, cmd2;
    logic [WORD_W-1:0] adr1, data;
    logic [HADR_W-1:0] adr2;
    logic              rdy, done, cap_en;
    logic [1:0]        cap_idx;
    logic [7:0]        cap_byte;

    nps_rb_sync u_sync (
        .clk (clk), .rst (rst), .rb_n (nf_rb_n), .rdy (rdy)
    );

    nps_regs u_regs (
        .clk (clk), .rst (rst),
        .wr_en (wr_en), .wr_sel (wr_sel), .wr_data (wr_data),
        .done (done), .cap_en (cap_en), .cap_idx (cap_idx), .cap_byte (cap_byte),
        .cmd1 (cmd1), .cmd2 (cmd2), .adr1 (adr1), .adr2 (adr2),
        .ctrl (ctrl), .data (data)
    );

    nps_engine #(.T_LO (T_LO), .T_HI (T_HI), .WB_CYC (WB_CYC)) u_eng (
        .clk (clk), .rst (rst), .ctrl (ctrl),
        .cmd1 (cmd1), .cmd2 (cmd2), .adr1 (adr1), .adr2 (adr2), .data (data),
        .rdy (rdy), .dq_in (nf_dq_in),
        .ce_n (nf_ce_n), .cle (nf_cle), .ale (nf_ale),
        .we_n (nf_we_n), .re_n (nf_re_n),
        .dq_out (nf_dq_out), .dq_oe (nf_dq_oe),
        .cap_en (cap_en), .cap_idx (cap_idx), .cap_byte (cap_byte),
        .done (done)
    );

    assign go_o   = ctrl.go;
    assign rdy_o  = rdy;
    assign data_o = data;
endmodule

// File: tb/sim_nand_pio_seq.sv
module sim_nand_pio_seq;
    localparam int T_LO = 2;
    localparam int T_HI = 2;
    localparam int BUSY = 15;

    localparam logic [13:0] B_GO = 14'h0001, B_CLE = 14'h0002, B_ALE = 14'h0004,
                            B_PIO = 14'h0008, B_RX = 14'h0010, B_TX = 14'h0020,
                            B_SEC = 14'h0040, B_AFT = 14'h0080, B_CE = 14'h0100;
    function automatic logic [13:0] SZ(int n);  return 14'(n) << 9;  endfunction
    function automatic logic [13:0] NA(int n);  return 14'(n) << 11; endfunction

    typedef struct packed {
        logic [13:0] ctrl;
        logic [7:0]  c1, c2;
        logic [31:0] a1, a2, dpre, dexp;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VT [NV] = '{
        '{B_GO|B_CLE|B_ALE|B_PIO|B_RX|B_SEC|B_CE|SZ(3)|NA(5), 8'h00, 8'h30,
          32'h1234_0056, 32'h0000_0003, 32'h0, 32'hA3A2_A1A0},
        '{B_GO|B_CLE|B_ALE|B_SEC|B_CE|NA(3), 8'h60, 8'hD0,
          32'h0045_6789, 32'h0, 32'h0102_0304, 32'h0102_0304},
        '{B_GO|B_CLE|B_ALE|B_PIO|B_RX|B_SEC|B_CE|SZ(1)|NA(2), 8'h05, 8'hE0,
          32'h0000_0207, 32'h0, 32'h1122_3344, 32'h1122_A1A0},
        '{B_GO|B_CLE|B_ALE|B_PIO|B_TX|B_SEC|B_AFT|B_CE|SZ(2)|NA(7), 8'h80, 8'h10,
          32'h7654_0010, 32'h0000_0001, 32'hCCBB_AA99, 32'hCCBB_AA99},
        '{B_GO|B_CLE|B_PIO|B_RX|B_CE|SZ(0), 8'h70, 8'h00,
          32'h0, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFA0},
        '{B_GO|B_CLE|B_CE, 8'hFF, 8'h00,
          32'h0, 32'h0, 32'h0, 32'h0},
        '{B_GO|B_CLE|B_ALE|B_PIO|B_RX|B_CE|SZ(3)|NA(1), 8'h90, 8'h00,
          32'h0, 32'h0, 32'h0, 32'hA3A2_A1A0},
        '{B_GO|B_ALE|B_PIO|B_TX|SZ(3), 8'h00, 8'h00,
          32'h0, 32'h0, 32'h4433_2211, 32'h4433_2211}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic wr_en = 1'b0;
    logic [2:0] wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic go_o, rdy_o, nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
    logic [31:0] data_o;
    logic [7:0] nf_dq_out, nf_dq_in;
    logic nf_rb_n;
    logic force_busy = 1'b0;

    always #2 clk = ~clk;

    nand_pio_seq #(.T_LO(T_LO), .T_HI(T_HI), .WB_CYC(3)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .go_o(go_o), .rdy_o(rdy_o), .data_o(data_o),
        .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale),
        .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
        .nf_dq_out(nf_dq_out), .nf_dq_oe(nf_dq_oe),
        .nf_dq_in(nf_dq_in), .nf_rb_n(nf_rb_n)
    );

    // flash model and bus monitor, sole writer of its state
    int busy_cnt = 0, rd_idx = 0, n_log = 0;
    int viol = 0, ce_gap = 0, ce_low = 0, wid_bad = 0, we_lo = 0, re_lo = 0;
    logic prev_we = 1'b1, prev_re = 1'b1;
    logic [1:0] log_k [128];
    logic [7:0] log_v [128];

    assign nf_rb_n  = (busy_cnt == 0) && !force_busy;
    assign nf_dq_in = 8'(8'hA0 + rd_idx);

    always @(negedge clk) begin
        if (!rst) begin
            if (busy_cnt != 0) busy_cnt = busy_cnt - 1;
            if (!nf_ce_n) ce_low = ce_low + 1;
            if ((prev_we && !nf_we_n) || (prev_re && !nf_re_n)) begin
                if (!nf_rb_n) viol = viol + 1;
                if (nf_ce_n)  ce_gap = ce_gap + 1;
            end
            if (!nf_we_n) we_lo = we_lo + 1;
            if (!nf_re_n) re_lo = re_lo + 1;
            if (!prev_we && nf_we_n) begin
                if (we_lo != T_LO) wid_bad = wid_bad + 1;
                we_lo = 0;
                if (n_log < 128) begin
                    log_k[n_log] = nf_cle ? 2'd0 : (nf_ale ? 2'd1 : 2'd2);
                    log_v[n_log] = nf_dq_out;
                    n_log = n_log + 1;
                end
                if (nf_cle) begin
                    rd_idx = 0;
                    if (nf_dq_out == 8'h30 || nf_dq_out == 8'h10 || nf_dq_out == 8'hD0)
                        busy_cnt = BUSY;
                end
            end
            if (!prev_re && nf_re_n) begin
                if (re_lo != T_LO) wid_bad = wid_bad + 1;
                re_lo = 0;
                rd_idx = rd_idx + 1;
            end
            prev_we = nf_we_n;
            prev_re = nf_re_n;
        end
    end

    int total = 0, bad = 0;
    int n_exp;
    logic [1:0] exp_k [32];
    logic [7:0] exp_v [32];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic push(input logic [1:0] k, input logic [7:0] v);
        exp_k[n_exp] = k; exp_v[n_exp] = v; n_exp = n_exp + 1;
    endtask

    // expected bus write sequence from R2/R3/R4/R6
    task automatic build(input vec_t v);
        logic [39:0] adr;
        int na, sz;
        n_exp = 0;
        adr = {v.a2[7:0], v.a1};
        na = (int'(v.ctrl[13:11]) > 5) ? 5 : int'(v.ctrl[13:11]);
        sz = int'(v.ctrl[10:9]) + 1;
        if (v.ctrl[1]) push(2'd0, v.c1);
        if (v.ctrl[2]) for (int i = 0; i < na; i++) push(2'd1, adr[8*i +: 8]);
        if (v.ctrl[6] && !v.ctrl[7]) push(2'd0, v.c2);
        if (v.ctrl[3] && !v.ctrl[4] && v.ctrl[5])
            for (int i = 0; i < sz; i++) push(2'd2, v.dpre[8*i +: 8]);
        if (v.ctrl[6] && v.ctrl[7]) push(2'd0, v.c2);
    endtask

    task automatic wait_idle(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            if (!go_o) begin ok = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic run_vec(input vec_t v);
        int b_log, b_viol, b_gap, b_ce, b_wid, mism;
        bit ok;
        wr(3'd5, v.dpre); wr(3'd0, {24'h0, v.c1}); wr(3'd1, {24'h0, v.c2});
        wr(3'd2, v.a1);   wr(3'd3, v.a2);
        b_log = n_log; b_viol = viol; b_gap = ce_gap; b_ce = ce_low; b_wid = wid_bad;
        wr(3'd4, {18'h0, v.ctrl});
        check(go_o == 1'b1, "R8", "go set after start", {31'h0, go_o}, 32'h1);
        wait_idle(ok);
        check(ok, "R8", "go cleared on completion", {31'h0, go_o}, 32'h0);
        check(rdy_o == 1'b1, "R7", "ready when go clears", {31'h0, rdy_o}, 32'h1);
        check(viol == b_viol, "R7", "strobe while busy", viol - b_viol, 0);
        build(v);
        mism = (n_log - b_log == n_exp) ? 0 : 1;
        for (int i = 0; i < n_exp && mism == 0; i++)
            if (log_k[b_log+i] != exp_k[i] || log_v[b_log+i] != exp_v[i]) mism = 1;
        check(mism == 0, "R2/R3/R4/R6", "bus write sequence", n_log - b_log, n_exp);
        check(data_o == v.dexp, "R5", "data register", data_o, v.dexp);
        if (v.ctrl[8])
            check(ce_gap == b_gap && ce_low > b_ce, "R9", "ce low during strobes",
                  ce_gap - b_gap, 0);
        else
            check(ce_low == b_ce, "R9", "ce stays high", ce_low - b_ce, 0);
        check(wid_bad == b_wid, "R10", "strobe low width", wid_bad - b_wid, 0);
    endtask

    initial begin
        int b_log;
        bit ok;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(go_o == 0 && data_o == 0 && rdy_o == 1, "R1", "reset regs",
              data_o, 32'h0);
        check(nf_ce_n && nf_we_n && nf_re_n && !nf_cle && !nf_ale && !nf_dq_oe,
              "R1", "reset pins", {26'h0, nf_ce_n, nf_we_n, nf_re_n, nf_cle, nf_ale, nf_dq_oe},
              32'h38);

        for (int v = 0; v < NV; v++) run_vec(VT[v]);

        // R11: synchroniser latency
        @(negedge clk); force_busy = 1'b1;
        @(negedge clk);
        check(rdy_o == 1'b1, "R11", "one edge after busy", {31'h0, rdy_o}, 32'h1);
        @(negedge clk);
        check(rdy_o == 1'b0, "R11", "two edges after busy", {31'h0, rdy_o}, 32'h0);
        force_busy = 1'b0;
        repeat (2) @(negedge clk);
        check(rdy_o == 1'b1, "R11", "ready returns", {31'h0, rdy_o}, 32'h1);

        // R12: writes while running are dropped
        wr(3'd5, 32'h5566_7788); wr(3'd0, 32'h60); wr(3'd1, 32'hD0);
        wr(3'd2, 32'h0); wr(3'd3, 32'h0);
        b_log = n_log;
        wr(3'd4, {18'h0, B_GO|B_CLE|B_ALE|B_SEC|B_CE|NA(3)});
        wr(3'd5, 32'hDEAD_BEEF);
        wr(3'd4, {18'h0, B_GO|B_CLE|B_CE});
        wr(3'd0, 32'h11);
        wait_idle(ok);
        check(data_o == 32'h5566_7788, "R12", "data kept", data_o, 32'h5566_7788);
        repeat (10) @(negedge clk);
        check(go_o == 1'b0 && n_log - b_log == 5, "R12", "no restart",
              n_log - b_log, 5);
        b_log = n_log;
        wr(3'd4, {18'h0, B_GO|B_CLE|B_CE});
        wait_idle(ok);
        check(n_log - b_log == 1 && log_v[b_log] == 8'h60, "R12", "cmd kept",
              {24'h0, log_v[b_log]}, 32'h60);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
        $finish;
    end
endmodule